// File: doc/BRIEF.md
# Sliding-Window Power-Gated Flit Buffer

This block is a virtual-channel flit buffer whose storage entries each sit in their own power domain. A window of consecutive entries, starting at the write position and running forward around the ring, is kept powered at all times. A short packet can therefore land in the buffer at full rate without waiting for any supply to come up. Each accepted write moves the window one entry forward. An entry that enters the window at its far end starts a wake sequence of a fixed number of cycles.

An entry that has been read and no longer lies inside the window is switched off. An entry that still holds unread data is never switched off. Each entry's power state is visible on a packed output bus, so a power controller or monitor can follow it. Reads use show-ahead: the oldest flit is on `rd_data` whenever the buffer is not empty. The write side sees `wr_ready` drop while the entry at the write position is still waking, and also while the buffer is full.

The parameters are the flit width, the depth (a power of two), the window size (2 and 3 are the intended values) and the wake time (at least 2 cycles). The reset input is asynchronous and active low. It is released through a two-stage synchroniser, so the buffer leaves reset two clock edges after `rst_n` rises.

Top module: `win_gated_fifo`

## Requirements
- R1: After reset the buffer is empty (`empty`=1, `full`=0, `wr_ready`=1). The entries 0 to WIN-1 report powered and all others report off. The power state of entry i is `pwr_state[2i+1:2i]`, coded 0 = off, 1 = waking, 2 = powered.
- R2: Flits leave in the order they were written. `rd_data` shows the oldest flit while `empty`=0. A read happens on a clock edge where `rd_en`=1 and `empty`=0.
- R3: `full` rises once DEPTH flits are held. While `full`=1, `wr_ready`=0 and a flit presented with `wr_valid`=1 is dropped without changing the contents.
- R4: `rd_en` while `empty`=1 has no effect: no pointer moves, and the next flit written is the next flit read.
- R5: An entry that enters the window reads 0 until the next clock edge and 1 from that edge onward. It reads 2 from the WAKE_CYC-th edge after it entered.
- R6: `wr_ready` is 1 only when the buffer is not full and the entry at the write position is powered. A burst of up to WIN flits written from reset is accepted with no stall. A longer burst stalls only while its target entry is still waking.
- R7: Every entry that holds unread data reports 2.
- R8: An entry that is read and lies outside the window reports 2 up to the edge after the read and reports 0 from then on. An entry inside the window stays at 2.
- R9: A write and a read on the same edge leave the fill level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid | input | 1 | A flit is offered on `wr_data` |
| wr_data | input | WIDTH | Flit to write |
| wr_ready | output | 1 | The offered flit is taken on this edge |
| rd_en | input | 1 | Pop the oldest flit |
| rd_data | output | WIDTH | Oldest flit (show-ahead) |
| empty | output | 1 | No flit held |
| full | output | 1 | DEPTH flits held |
| pwr_state | output | 2*DEPTH | Per-entry power state, 2 bits per entry |

## Verification
The hardest state to reach is a window that wraps past the end of the ring onto entries that have just been drained or still hold data. In that state, whether an entry is kept on, woken or gated depends on both pointers at once. The bench first pushes six flits, which puts the write position near the ring end. It then drains them, so the window covers entry 0 while entries 1 to 5 must go dark one by one. A full refill from that offset makes every entry hold data across the wrap point, and a blocked write is attempted in that state. The stall pattern of the first long burst is predicted by a small timing model built from the window and wake parameters.

// File: rtl/wgf_pkg.sv
package wgf_pkg;
  typedef enum logic [1:0] {
    PWR_OFF  = 2'd0,
    PWR_WAKE = 2'd1,
    PWR_ON   = 2'd2
  } pwr_t;
endpackage

// File: rtl/wgf_ptrs.sv
module wgf_ptrs #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire,
  input  logic          rd_fire,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [AW:0]   count,
  output logic          full,
  output logic          empty
);
  logic [AW:0] wr_q, wr_n, rd_q, rd_n;

  always_comb begin
    wr_n = wr_q;
    rd_n = rd_q;
    if (wr_fire) wr_n = wr_q + (AW+1)'(1);
    if (rd_fire) rd_n = rd_q + (AW+1)'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (wr_fire) wr_q <= wr_n;
      if (rd_fire) rd_q <= rd_n;
    end
  end

  assign wr_ptr = wr_q[AW-1:0];
  assign rd_ptr = rd_q[AW-1:0];
  assign count  = wr_q - rd_q;
  assign empty  = (wr_q == rd_q);
  assign full   = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_fire);
  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !wr_fire) |=> empty);
  // R9
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire == rd_fire) |=> $stable(count));
endmodule

// File: rtl/wgf_cell_pwr.sv
module wgf_cell_pwr
  import wgf_pkg::*;
#(
  parameter int WAKE_CYC = 3,
  parameter bit RST_ON   = 1'b0,
  localparam int CW = $clog2(WAKE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_win,
  input  logic occupied,
  output pwr_t state
);
  pwr_t          st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          need;

  assign need = in_win | occupied;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    unique case (st_q)
      PWR_OFF: if (need) begin
        st_n  = PWR_WAKE;
        cnt_n = CW'(WAKE_CYC - 1);
      end
      PWR_WAKE: begin
        cnt_n = cnt_q - CW'(1);
        if (!need)                 st_n = PWR_OFF;
        else if (cnt_q == CW'(1))  st_n = PWR_ON;
      end
      PWR_ON:  if (!need) st_n = PWR_OFF;
      default: st_n = PWR_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RST_ON ? PWR_ON : PWR_OFF;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  assign state = st_q;

  // R7
  data_kept_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupied |-> (st_q == PWR_ON));
  // R5
  win_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && st_q == PWR_OFF) |=> (st_q == PWR_WAKE));
  // R8
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_win && !occupied) |=> (st_q == PWR_OFF));
endmodule

// File: rtl/wgf_store.sv
module wgf_store #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/win_gated_fifo.sv
module win_gated_fifo
  import wgf_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int DEPTH    = 8,
  parameter int WIN      = 3,
  parameter int WAKE_CYC = 3,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic [WIDTH-1:0]   wr_data,
  output logic               wr_ready,
  input  logic               rd_en,
  output logic [WIDTH-1:0]   rd_data,
  output logic               empty,
  output logic               full,
  output logic [2*DEPTH-1:0] pwr_state
);
  localparam logic [AW:0] WIN_L = (AW+1)'(WIN);

  logic             rst_s1, rst_sync_n;
  logic             wr_fire, rd_fire;
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      count;
  logic [DEPTH-1:0] occ, in_win;
  pwr_t             st [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  assign wr_ready = !full && (st[wr_ptr] == PWR_ON);
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_fire  = rd_en && !empty;

  wgf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_sync_n), .wr_fire(wr_fire), .rd_fire(rd_fire),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count), .full(full), .empty(empty)
  );

  wgf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .wr_en(wr_fire), .wr_addr(wr_ptr), .wr_data(wr_data),
    .rd_addr(rd_ptr), .rd_data(rd_data)
  );

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic [AW-1:0] dr, dw;
      dr        = AW'(i) - rd_ptr;
      dw        = AW'(i) - wr_ptr;
      occ[i]    = ({1'b0, dr} < count);
      in_win[i] = ({1'b0, dw} < WIN_L);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    wgf_cell_pwr #(.WAKE_CYC(WAKE_CYC), .RST_ON(g < WIN)) u_cell (
      .clk(clk), .rst_n(rst_sync_n), .in_win(in_win[g]),
      .occupied(occ[g]), .state(st[g])
    );
    assign pwr_state[2*g +: 2] = st[g];
  end

  // R6
  win_head_ready_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_valid && !full && st[wr_ptr] == PWR_ON) |=> !empty);
endmodule

// File: tb/win_gated_fifo_bench.sv
module win_gated_fifo_bench;
  localparam int WIDTH = 32, DEPTH = 8, WIN = 3, WAKE = 3;

  logic               clk = 1'b0;
  logic               rst_n, wr_valid, rd_en;
  logic [WIDTH-1:0]   wr_data;
  logic               wr_ready, empty, full;
  logic [WIDTH-1:0]   rd_data;
  logic [2*DEPTH-1:0] pwr_state;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  win_gated_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH), .WIN(WIN), .WAKE_CYC(WAKE)) u_win_gated_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .full(full), .pwr_state(pwr_state)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] ps(input int i);
    return pwr_state[2*i +: 2];
  endfunction

  // called at a negedge; returns at the negedge after the write edge
  task automatic push(input logic [WIDTH-1:0] d, output int stalls);
    stalls = 0;
    wr_valid = 1'b1; wr_data = d; #1;
    while (!wr_ready && stalls < 50) begin stalls++; @(negedge clk); #1; end
    @(negedge clk);
  endtask

  task automatic pop(output logic [WIDTH-1:0] d);
    #1; d = rd_data; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    wr_valid = 1'b0; rd_en = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 wr_ready", wr_ready, 1);
    for (int i = 0; i < DEPTH; i++)
      chk($sformatf("R1 pwr entry %0d", i), ps(i), (i < WIN) ? 2 : 0);
  endtask

  task automatic t_stream;
    int w [6];
    int st;
    for (int k = 0; k < 6; k++) begin
      int on_e, prev;
      prev = (k == 0) ? 0 : w[k-1];
      on_e = (k < WIN) ? 0 : w[k-WIN] + WAKE;
      w[k] = (prev + 1 > on_e + 1) ? prev + 1 : on_e + 1;
    end
    for (int k = 0; k < 6; k++) begin
      int exp_st;
      push(32'h100 + k, st);
      exp_st = w[k] - ((k == 0) ? 0 : w[k-1]) - 1;
      chk($sformatf("R6 stall before flit %0d", k), st, exp_st);
      if (k < WIN) begin
        int e;
        e = (k + 1 < 2) ? 0 : ((k + 1 < 1 + WAKE) ? 1 : 2);
        chk($sformatf("R5 entry %0d after edge %0d", WIN, k + 1), ps(WIN), e);
      end
    end
    idle(1);
    for (int i = 0; i < 6; i++) chk($sformatf("R7 held entry %0d on", i), ps(i), 2);
    idle(4);
    for (int i = 6; i < DEPTH; i++) chk($sformatf("R5 window entry %0d on", i), ps(i), 2);
  endtask

  task automatic t_drain;
    logic [WIDTH-1:0] d;
    for (int k = 0; k < 6; k++) begin
      pop(d);
      chk($sformatf("R2 order flit %0d", k), d, 32'h100 + k);
      if (k >= 1) chk($sformatf("R8 entry %0d on at read edge", k), ps(k), 2);
      if (k >= 2) chk($sformatf("R8 entry %0d gated", k - 1), ps(k - 1), 0);
    end
    chk("R2 empty after drain", empty, 1);
    idle(1);
    for (int i = 0; i < DEPTH; i++)
      chk($sformatf("R8 map entry %0d", i), ps(i), (((i - 6 + DEPTH) % DEPTH) < WIN) ? 2 : 0);
  endtask

  task automatic t_full;
    logic [WIDTH-1:0] d;
    int st;
    for (int k = 0; k < DEPTH; k++) push(32'h200 + k, st);
    wr_valid = 1'b0; #1;
    chk("R3 full", full, 1);
    chk("R3 wr_ready low", wr_ready, 0);
    for (int i = 0; i < DEPTH; i++) chk($sformatf("R7 full entry %0d", i), ps(i), 2);
    wr_valid = 1'b1; wr_data = 32'hDEAD;
    repeat (3) @(negedge clk);
    wr_valid = 1'b0; #1;
    chk("R3 still full", full, 1);
    for (int k = 0; k < DEPTH; k++) begin
      pop(d);
      chk($sformatf("R3 content %0d", k), d, 32'h200 + k);
    end
    #1;
    chk("R3 empty after drain", empty, 1);
  endtask

  task automatic t_empty_read;
    logic [WIDTH-1:0] d;
    int st;
    idle(4);
    rd_en = 1'b1;
    repeat (3) @(negedge clk);
    rd_en = 1'b0; #1;
    chk("R4 empty kept", empty, 1);
    push(32'h55, st);
    wr_valid = 1'b0;
    pop(d);
    chk("R4 next read", d, 32'h55);
    #1;
    chk("R4 empty again", empty, 1);
  endtask

  task automatic t_simul;
    logic [WIDTH-1:0] d;
    int st;
    push(32'h60, st);
    idle(5);
    wr_valid = 1'b1; wr_data = 32'h61; rd_en = 1'b1; #1;
    chk("R9 ready", wr_ready, 1);
    chk("R2 head", rd_data, 32'h60);
    @(negedge clk);
    wr_valid = 1'b0; rd_en = 1'b0; #1;
    chk("R9 not empty", empty, 0);
    chk("R9 new head", rd_data, 32'h61);
    pop(d);
    #1;
    chk("R9 empty", empty, 1);
  endtask

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; rd_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_stream();
    t_drain();
    t_full();
    t_empty_read();
    t_simul();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule